// File: doc/BRIEF.md
# Serial ADC Host Frame Controller

This block drives a 16-channel, 12-bit successive-approximation converter that sits on a four-wire serial link. On a start request it pulls the active-low select line down, toggles a serial clock derived from the system clock, and shifts out a 16-bit control word. In the same frame it gathers the 16-bit reply, which is a channel tag followed by the sample. When the select line rises again, the block hands the tag and the decoded sample to a parallel valid/ready consumer.

The converter runs its conversion from the same serial clock, and it returns the result within the frame that started that conversion. A control word takes effect only after the frame that carries it has ended. For that reason the coding the block applies to a sample is the coding bit it sent in the previous frame. The block tracks that bit itself and reports it next to the sample.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the select line and the serial clock are high, the serial data output is low, and no result is valid.
- R2: Every frame contains exactly 16 falling edges of the serial clock while select is low. The serial clock is high whenever select is high.
- R3: The control word is sent most significant bit first with this layout: bit 15 sequence enable, bits 14:11 channel, bit 10 shadow, bit 9 range, bit 8 coding (1 = two's complement), bits 7:0 zero. The data line changes only at a frame start or at a rising serial clock edge, so it is stable at every falling edge.
- R4: Returned bits are captured at each rising serial clock edge. The first four form the channel tag on `res_chan_o`, and the last twelve form the sample, most significant bit first.
- R5: A sample in straight binary coding is zero-extended to RES_W bits, and `res_twos_o` is 0.
- R6: A sample in two's complement is sign-extended to RES_W bits, and `res_twos_o` is 1. The coding applied is the coding bit of the preceding frame, or straight binary for the first frame after reset.
- R7: Select low to the first falling edge is HALF_DIV clocks. Every later serial clock phase is HALF_DIV clocks, and select rises HALF_DIV clocks after the 16th rising edge, so select stays low for 33*HALF_DIV clocks.
- R8: Select stays high for at least QUIET_CYC clocks between frames.
- R9: `res_valid_o` rises exactly one clock after select rises at the end of a frame.
- R10: While `res_valid_o` is high and `res_ready_i` is low, the result outputs hold their values and `start_i` starts no frame.
- R11: A start request in the same cycle that an idle block's pending result is accepted starts a frame at once.
- R12: A start request during a frame or the quiet time neither changes the word being sent nor launches an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only when idle and the result slot is free |
| cfg_chan_i | input | 4 | Channel field of the control word |
| cfg_seq_i | input | 1 | Sequence-enable field |
| cfg_shadow_i | input | 1 | Shadow field |
| cfg_range_i | input | 1 | Input-range field |
| cfg_twos_i | input | 1 | Coding field, 1 = two's complement |
| adc_cs_no | output | 1 | Active-low select to the converter |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_sdi_o | output | 1 | Control bits to the converter |
| adc_sdo_i | input | 1 | Reply bits from the converter |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_chan_o | output | 4 | Returned channel tag |
| res_sample_o | output | RES_W (16) | Sample, zero- or sign-extended |
| res_twos_o | output | 1 | Coding used for this sample |

## Verification
Acceptance of a pending result and the start of a new frame can land in the same clock. When that happens, the slot freed by `res_ready_i` must let `start_i` through in that very cycle. The bench holds a result with `res_ready_i` low while `start_i` stays high, and checks that no frame starts and that the outputs do not move. It then raises ready and start on the same edge and expects select to fall one clock later with valid dropped. Start pulses placed inside a frame are judged by comparing the word the behavioural converter captured against the original request, and by counting frames.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int FRAME_BITS = 16;
  localparam int TAG_W      = 4;
  localparam int SMP_W      = 12;

  typedef struct packed {
    logic       seq;
    logic [3:0] chan;
    logic       shadow;
    logic       range;
    logic       twos;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_DONE,
    ST_QUIET
  } fsm_e;

  function automatic logic [FRAME_BITS-1:0] pack_ctl(ctl_t c);
    return {c, {(FRAME_BITS - $bits(ctl_t)){1'b0}}};
  endfunction
endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         sdo_i,
  output logic         sdi_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= load_val_i;
      rx_q <= '0;
    end else if (step_i) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
      rx_q <= {rx_q[W-2:0], sdo_i};
    end
  end

  assign sdi_o = tx_q[W-1];
  assign rx_o  = rx_q;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
  import adc_frame_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  twos_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic [TAG_W-1:0]      chan_o,
  output logic [RES_W-1:0]      sample_o,
  output logic                  twos_o
);
  logic [SMP_W-1:0] raw;
  logic [RES_W-1:0] ext;

  assign raw = frame_i[SMP_W-1:0];

  if (RES_W > SMP_W) begin : g_ext
    assign ext = twos_i ? {{(RES_W - SMP_W){raw[SMP_W-1]}}, raw}
                        : {{(RES_W - SMP_W){1'b0}}, raw};
  end else begin : g_flat
    assign ext = raw[RES_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      chan_o   <= '0;
      sample_o <= '0;
      twos_o   <= 1'b0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      chan_o   <= frame_i[FRAME_BITS-1 -: TAG_W];
      sample_o <= ext;
      twos_o   <= twos_i;
    end else if (ready_i) begin
      valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 4,
  parameter int RES_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       cfg_chan_i,
  input  logic             cfg_seq_i,
  input  logic             cfg_shadow_i,
  input  logic             cfg_range_i,
  input  logic             cfg_twos_i,
  output logic             adc_cs_no,
  output logic             adc_sclk_o,
  output logic             adc_sdi_o,
  input  logic             adc_sdo_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [3:0]       res_chan_o,
  output logic [RES_W-1:0] res_sample_o,
  output logic             res_twos_o
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int QW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;

  fsm_e            st_q;
  logic            cs_n_q, sclk_q;
  logic [BW-1:0]   bit_q;
  logic [QW-1:0]   quiet_q;
  logic            tw_pend_q, tw_cur_q;
  logic            run, tick, step, start_go, load_res, last_bit;
  logic [FRAME_BITS-1:0] rx;
  ctl_t            ctl;

  assign ctl      = '{seq: cfg_seq_i, chan: cfg_chan_i, shadow: cfg_shadow_i,
                      range: cfg_range_i, twos: cfg_twos_i};
  assign run      = (st_q == ST_SETUP) || (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign step     = (st_q == ST_LOW) && tick;
  assign last_bit = (bit_q == BW'(FRAME_BITS - 1));
  assign load_res = (st_q == ST_DONE);
  // result slot counts as free in the cycle the consumer takes it
  assign start_go = (st_q == ST_IDLE) && start_i && (!res_valid_o || res_ready_i);

  adc_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  adc_frame_shift #(.W(FRAME_BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_go),
    .load_val_i (pack_ctl(ctl)),
    .step_i     (step),
    .sdo_i      (adc_sdo_i),
    .sdi_o      (adc_sdi_o),
    .rx_o       (rx)
  );

  adc_result_reg #(.RES_W(RES_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_res),
    .frame_i  (rx),
    .twos_i   (tw_cur_q),
    .ready_i  (res_ready_i),
    .valid_o  (res_valid_o),
    .chan_o   (res_chan_o),
    .sample_o (res_sample_o),
    .twos_o   (res_twos_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cs_n_q    <= 1'b1;
      sclk_q    <= 1'b1;
      bit_q     <= '0;
      quiet_q   <= '0;
      tw_pend_q <= 1'b0;
      tw_cur_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_go) begin
          st_q      <= ST_SETUP;
          cs_n_q    <= 1'b0;
          bit_q     <= '0;
          // converter applies a control word only after its frame ends
          tw_cur_q  <= tw_pend_q;
          tw_pend_q <= cfg_twos_i;
        end
        ST_SETUP: if (tick) begin
          sclk_q <= 1'b0;
          st_q   <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk_q <= 1'b1;
          st_q   <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          if (last_bit) begin
            cs_n_q <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            sclk_q <= 1'b0;
            bit_q  <= bit_q + 1'b1;
            st_q   <= ST_LOW;
          end
        end
        ST_DONE: begin
          quiet_q <= '0;
          st_q    <= ST_QUIET;
        end
        ST_QUIET: begin
          if (quiet_q == QW'(QUIET_CYC - 1)) st_q <= ST_IDLE;
          else                               quiet_q <= quiet_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_cs_no  = cs_n_q;
  assign adc_sclk_o = sclk_q;
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
module adc_frame_ctrl_chk #(
  parameter int HALF_DIV = 2,
  parameter int RES_W    = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adc_cs_no,
  input logic             adc_sclk_o,
  input logic             adc_sdi_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [3:0]       res_chan_o,
  input logic [RES_W-1:0] res_sample_o,
  input logic             res_twos_o
);
  logic        cs_d, sclk_d;
  logic [15:0] gap_q;
  logic [5:0]  falls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d    <= 1'b1;
      sclk_d  <= 1'b1;
      gap_q   <= '0;
      falls_q <= '0;
    end else begin
      cs_d   <= adc_cs_no;
      sclk_d <= adc_sclk_o;
      if ((cs_d && !adc_cs_no) || (sclk_d != adc_sclk_o)) gap_q <= '0;
      else if (gap_q != '1)                               gap_q <= gap_q + 1'b1;
      if (cs_d && !adc_cs_no) falls_q <= '0;
      else if (sclk_d && !adc_sclk_o && !adc_cs_no && falls_q != '1)
        falls_q <= falls_q + 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> adc_sclk_o);

  assert_sixteen_falls_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_d && adc_cs_no) |-> (falls_q == 6'd16));

  assert_sdi_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_sclk_o) |-> $stable(adc_sdi_o));

  assert_half_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adc_cs_no && (sclk_d != adc_sclk_o)) |-> (gap_q == 16'(HALF_DIV - 1)));

  assert_valid_after_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_cs_no) |=> $rose(res_valid_o));

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_sample_o) && $stable(res_chan_o) && $stable(res_twos_o)));

  assert_no_start_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> !$fell(adc_cs_no));
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.HALF_DIV(HALF_DIV), .RES_W(RES_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adc_cs_no    (adc_cs_no),
  .adc_sclk_o   (adc_sclk_o),
  .adc_sdi_o    (adc_sdi_o),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .res_chan_o   (res_chan_o),
  .res_sample_o (res_sample_o),
  .res_twos_o   (res_twos_o)
);

// File: tb/tb_adc_frame_ctrl.sv
module tb_adc_frame_ctrl;
  localparam int HALF  = 2;
  localparam int QUIET = 4;
  localparam int RES_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start, cfg_seq, cfg_shadow, cfg_range, cfg_twos, ready;
  logic [3:0] cfg_chan;
  logic cs_n, sclk, sdi;
  logic sdo = 1'b0;
  logic valid, tw;
  logic [3:0] chan;
  logic [RES_W-1:0] smp;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_frame_ctrl #(.HALF_DIV(HALF), .QUIET_CYC(QUIET), .RES_W(RES_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cfg_chan_i(cfg_chan), .cfg_seq_i(cfg_seq), .cfg_shadow_i(cfg_shadow),
    .cfg_range_i(cfg_range), .cfg_twos_i(cfg_twos),
    .adc_cs_no(cs_n), .adc_sclk_o(sclk), .adc_sdi_o(sdi), .adc_sdo_i(sdo),
    .res_valid_o(valid), .res_ready_i(ready), .res_chan_o(chan),
    .res_sample_o(smp), .res_twos_o(tw)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural converter
  logic [11:0] m_val_next = '0;
  logic [3:0]  m_addr = '0;
  bit          m_twos = 1'b0;
  logic [15:0] m_out = '0, m_ctl = '0, m_ctl_last = '0;
  int m_idx = 0, m_falls = 0, m_falls_last = 0, m_frames = 0;

  always @(negedge cs_n) begin
    m_out = {m_addr, m_twos ? (m_val_next ^ 12'h800) : m_val_next};
    m_idx = 0; m_falls = 0; m_ctl = '0;
    m_frames++;
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      m_falls++;
      if (m_idx < 16) begin
        sdo   = m_out[15 - m_idx];
        m_ctl = {m_ctl[14:0], sdi};
        m_idx++;
      end
    end
  end

  always @(posedge cs_n) begin
    m_falls_last = m_falls;
    if (m_idx == 16) begin
      m_ctl_last = m_ctl;
      m_addr     = m_ctl[14:11];
      m_twos     = m_ctl[8];
    end
  end

  // R8 quiet-time monitor
  int hi_cnt = 0;
  bit seen_frame = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) hi_cnt++;
      else begin
        if (hi_cnt > 0 && seen_frame) chk(hi_cnt >= QUIET, "R8", "select high gap", hi_cnt, QUIET);
        if (hi_cnt > 0) seen_frame = 1'b1;
        hi_cnt = 0;
      end
    end
  end

  // bench-side expectations
  logic [3:0]  prev_addr = '0;
  bit          prev_tw = 1'b0;
  logic [15:0] exp_ctl;
  logic [3:0]  exp_tag;
  bit          exp_tw;
  logic [RES_W-1:0] exp_smp;

  function automatic logic [RES_W-1:0] exp_sample(logic [11:0] v, bit t);
    logic [11:0] raw;
    raw = t ? (v ^ 12'h800) : v;
    return t ? {{(RES_W-12){raw[11]}}, raw} : {{(RES_W-12){1'b0}}, raw};
  endfunction

  task automatic launch(input logic [3:0] ch, input bit sq, input bit sh, input bit rg,
                        input bit t, input logic [11:0] v, input bit with_ready);
    int n = 0;
    exp_ctl = {sq, ch, sh, rg, t, 8'h00};
    exp_tag = prev_addr;
    exp_tw  = prev_tw;
    exp_smp = exp_sample(v, prev_tw);
    prev_addr = ch;
    prev_tw   = t;
    m_val_next = v;
    cfg_chan = ch; cfg_seq = sq; cfg_shadow = sh; cfg_range = rg; cfg_twos = t;
    start = 1'b1;
    ready = with_ready;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && with_ready) begin
        chk(cs_n == 1'b0, "R11", "frame start on accept cycle", cs_n, 0);
        chk(valid == 1'b0, "R11", "result released", valid, 0);
      end
      ready = 1'b0;
    end while (cs_n && n < 1000);
    start = 1'b0;
  endtask

  task automatic finish_frame(input int poke);
    int low_cnt = 1;
    while (1) begin
      @(negedge clk);
      if (cs_n) break;
      low_cnt++;
      if (poke != 0 && low_cnt == poke) begin
        start = 1'b1; cfg_chan = ~cfg_chan; cfg_twos = ~cfg_twos; cfg_seq = ~cfg_seq;
      end else start = 1'b0;
      if (low_cnt > 1000) break;
    end
    start = 1'b0;
    chk(valid == 1'b0, "R9", "valid low at select rise", valid, 0);
    chk(low_cnt == 33 * HALF, "R7", "select low clocks", low_cnt, 33 * HALF);
    @(negedge clk);
    chk(valid == 1'b1, "R9", "valid one clock after select rise", valid, 1);
    chk(m_falls_last == 16, "R2", "falling edges per frame", m_falls_last, 16);
    chk(m_ctl_last == exp_ctl, poke != 0 ? "R12" : "R3", "control word", m_ctl_last, exp_ctl);
    chk(chan == exp_tag, "R4", "channel tag", chan, exp_tag);
    chk(smp == exp_smp, exp_tw ? "R6" : "R5", "sample", smp, exp_smp);
    chk(tw == exp_tw, "R6", "coding flag", tw, exp_tw);
  endtask

  task automatic accept_hold(input int d);
    int f = m_frames;
    start = 1'b1;
    repeat (d) begin
      @(negedge clk);
      chk(valid == 1'b1 && smp == exp_smp && chan == exp_tag, "R10", "result held", smp, exp_smp);
      chk(cs_n == 1'b1, "R10", "no frame while pending", cs_n, 1);
    end
    chk(m_frames == f, "R10", "frame count while pending", m_frames, f);
    start = 1'b0;
  endtask

  task automatic accept_plain();
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(valid == 1'b0, "R10", "valid drops after accept", valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    bit pend_ready;
    int fr;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; start = 1'b0; ready = 1'b0;
    cfg_chan = '0; cfg_seq = 0; cfg_shadow = 0; cfg_range = 0; cfg_twos = 0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 1, "R1", "select/clock in reset", {cs_n, sclk}, 2'b11);
    chk(sdi == 0 && valid == 0, "R1", "data/valid in reset", {sdi, valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && sdi == 0 && valid == 0, "R1", "idle after reset",
        {cs_n, sclk, sdi, valid}, 4'b1100);

    // directed corners
    launch(4'd5, 0, 0, 0, 1, 12'h123, 0); finish_frame(0); accept_hold(1); accept_plain();
    launch(4'd9, 1, 1, 0, 0, 12'h7FF, 0); finish_frame(0); accept_hold(0); accept_plain();
    launch(4'd3, 0, 0, 1, 1, 12'hFFF, 0); finish_frame(0); accept_hold(2); accept_plain();
    launch(4'd12, 1, 0, 1, 1, 12'h000, 0); finish_frame(0); accept_hold(25);
    launch(4'd7, 0, 1, 1, 0, 12'h800, 1); finish_frame(12); accept_hold(2); accept_plain();
    fr = m_frames;
    repeat (20) @(negedge clk);
    chk(m_frames == fr && cs_n == 1, "R12", "no extra frame after poke", m_frames, fr);

    // random frames
    pend_ready = 1'b0;
    for (int i = 0; i < 30; i++) begin
      int d;
      int poke;
      d    = $urandom_range(0, 10);
      poke = ($urandom_range(0, 3) == 0) ? $urandom_range(2, 33 * HALF - 1) : 0;
      launch(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             12'($urandom_range(0, 4095)), pend_ready);
      finish_frame(poke);
      accept_hold(d);
      if (d >= 8) pend_ready = 1'b1;
      else begin
        accept_plain();
        pend_ready = 1'b0;
      end
    end
    if (pend_ready) accept_plain();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule